// File: doc/BRIEF.md
# Cross-Correlation Loop Delay Estimator

This block measures how many sample periods separate a transmitted reference stream from the digitized feedback of that same stream. It is used during a calibration preamble, before live traffic. A start pulse makes the block capture a window of complex samples from both streams. It then computes a complex cross-correlation for each candidate lag, one multiply-accumulate per clock. The integer delay is the lag whose correlation magnitude is largest.

Around that peak, a three-point parabolic fit over the magnitudes at the peak lag and at its two neighbours gives a sub-sample fraction. The fraction is signed, with eight fractional bits, so its step is 1/256 of a sample. If the peak lands on either end of the searched range there are no two neighbours, so the fraction is forced to zero and an edge flag is raised.

Once an estimate exists, the host can enable tracking mode and pulse start at whatever cadence it chooses. Each tracking run searches only a few lags on either side of the last integer estimate. It replaces the stored result only when the new peak magnitude is above a programmable threshold, which lets the block follow slow thermal drift.

Top module: `dly_xcorr_est`

## Requirements
- R1: After synchronous reset `done`, `dly_int`, `dly_frac`, `peak_mag` and `on_edge` are all zero.
- R2: A start pulse accepted while idle makes the block capture the next N samples that arrive with `smp_vld` high, counted from index 0. Cycles with `smp_vld` low are skipped. For lag L the correlation is C(L) = sum over n = 0 .. N-LAGS-1 of fb[n+L]·conj(ref[n]), with samples written I + jQ.
- R3: The magnitude of a lag is |Re C(L)| + |Im C(L)|. `dly_int` is the lag with the largest magnitude, and the lowest such lag wins a tie. `peak_mag` is that magnitude.
- R4: A run started with `track_en` low, or before any estimate has been stored, searches every lag from 0 to LAGS-1 and always stores its result.
- R5: With peak magnitude m0, left neighbour mL and right neighbour mR, `dly_frac` = trunc(128·(mR−mL) / (2·m0−mL−mR)). Truncation is toward zero. The result is zero when the divisor is zero and is clamped to ±128. It is two's-complement, where 256 means one sample.
- R6: If the peak lag equals the lowest or highest lag of the range searched, `dly_frac` is 0 and `on_edge` is 1. Otherwise `on_edge` is 0.
- R7: `done` goes low on the cycle after a start is accepted and goes high when the run completes. The result outputs change only on the cycle in which `done` rises.
- R8: A run started with `track_en` high after an estimate has been stored searches only lags from last−2 to last+2, where last is the stored `dly_int`. This range is clamped to 0 .. LAGS-1.
- R9: A tracking run stores its result only when its peak magnitude is strictly greater than `trk_thr`. Otherwise all result outputs keep their previous values, but `done` still rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; taken only while idle |
| track_en | input | 1 | Select the narrowed tracking search |
| trk_thr | input | 26 | Tracking acceptance threshold on peak magnitude |
| smp_vld | input | 1 | Sample strobe for both streams |
| ref_i | input | 8 | Reference sample, in-phase (signed) |
| ref_q | input | 8 | Reference sample, quadrature (signed) |
| fb_i | input | 8 | Feedback sample, in-phase (signed) |
| fb_q | input | 8 | Feedback sample, quadrature (signed) |
| dly_int | output | 6 | Integer delay in samples |
| dly_frac | output | 9 | Sub-sample delay, signed, 1/256 sample units |
| peak_mag | output | 26 | Correlation magnitude at the peak lag |
| on_edge | output | 1 | Peak lies at an end of the searched range |
| done | output | 1 | Result ready |

## Verification
Internal faults in this block show up at the ports as soon as a run finishes, and not before. A wrong capture address, a bad read offset or a sign error in the complex multiply moves the peak. That is visible in `dly_int` or `peak_mag` when `done` rises. A wrong neighbour index or a divider error appears only in `dly_frac`. Stimuli with half-sample and quarter-sample feedback are therefore used, so the fraction is far from zero. Faults in the tracking range or in the acceptance compare appear only on the second run after a calibration, either as an edge flag in the wrong place or as a result that was stored when it should have been kept, or kept when it should have been stored.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CAP, S_CORR, S_WAIT, S_EVAL, S_FIT, S_DIV, S_POST
  } dly_st_t;
endpackage

// File: rtl/dly_cap_ram.sv
module dly_cap_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dly_cmac.sv
module dly_cmac #(
  parameter int W    = 8,
  parameter int ACCW = 25
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] r_i,
  input  logic signed [W-1:0] r_q,
  input  logic signed [W-1:0] f_i,
  input  logic signed [W-1:0] f_q,
  output logic [ACCW:0]       mag
);
  logic signed [2*W-1:0] p_ii, p_qq, p_qi, p_iq;
  logic signed [2*W:0]   t_re, t_im;
  logic signed [ACCW-1:0] acc_re, acc_im;
  logic [ACCW-1:0] abs_re, abs_im;

  always_comb begin
    p_ii = f_i * r_i;
    p_qq = f_q * r_q;
    p_qi = f_q * r_i;
    p_iq = f_i * r_q;
    t_re = {p_ii[2*W-1], p_ii} + {p_qq[2*W-1], p_qq};
    t_im = {p_qi[2*W-1], p_qi} - {p_iq[2*W-1], p_iq};
    abs_re = acc_re[ACCW-1] ? ACCW'(-acc_re) : ACCW'(acc_re);
    abs_im = acc_im[ACCW-1] ? ACCW'(-acc_im) : ACCW'(acc_im);
    mag = {1'b0, abs_re} + {1'b0, abs_im};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (en) begin
      acc_re <= acc_re + ACCW'(t_re);
      acc_im <= acc_im + ACCW'(t_im);
    end
  end
endmodule

// File: rtl/dly_frac_div.sv
module dly_frac_div #(
  parameter int MW = 26,
  parameter int FB = 8,
  localparam int XW = MW + FB + 1,
  localparam int CW = $clog2(FB + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [MW-1:0]       m_l,
  input  logic [MW-1:0]       m_c,
  input  logic [MW-1:0]       m_r,
  output logic                fin,
  output logic signed [FB:0]  frac
);
  localparam logic [FB:0] HALF = (FB+1)'(1) << (FB - 1);

  logic [XW-1:0] rem, dsh;
  logic [FB:0]   q;
  logic [CW-1:0] cnt;
  logic          busy, neg, zden;
  logic [MW-1:0] dif;
  logic [MW:0]   den;
  logic [FB:0]   qc;

  always_comb begin
    dif = (m_r < m_l) ? (m_l - m_r) : (m_r - m_l);
    den = {m_c, 1'b0} - {1'b0, m_l} - {1'b0, m_r};
    qc  = (q > HALF) ? HALF : q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      frac <= '0;
      rem  <= '0;
      dsh  <= '0;
      q    <= '0;
      cnt  <= '0;
      neg  <= 1'b0;
      zden <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        neg  <= (m_r < m_l);
        zden <= (den == '0);
        rem  <= XW'(dif) << (FB - 1);
        dsh  <= XW'(den) << FB;
        q    <= '0;
        cnt  <= CW'(FB + 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          fin  <= 1'b1;
          if (zden) frac <= '0;
          else      frac <= neg ? -$signed(qc) : $signed(qc);
        end else begin
          if (rem >= dsh) begin
            rem <= rem - dsh;
            q   <= {q[FB-1:0], 1'b1};
          end else begin
            q   <= {q[FB-1:0], 1'b0};
          end
          dsh <= dsh >> 1;
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dly_xcorr_est.sv
module dly_xcorr_est #(
  parameter int W        = 8,
  parameter int N        = 256,
  parameter int LAGS     = 64,
  parameter int FB       = 8,
  parameter int TRK_SPAN = 2,
  localparam int AW   = $clog2(N),
  localparam int LGW  = $clog2(LAGS),
  localparam int K    = N - LAGS,
  localparam int ACCW = 2*W + 1 + AW,
  localparam int MW   = ACCW + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                track_en,
  input  logic [MW-1:0]       trk_thr,
  input  logic                smp_vld,
  input  logic signed [W-1:0] ref_i,
  input  logic signed [W-1:0] ref_q,
  input  logic signed [W-1:0] fb_i,
  input  logic signed [W-1:0] fb_q,
  output logic [LGW-1:0]      dly_int,
  output logic signed [FB:0]  dly_frac,
  output logic [MW-1:0]       peak_mag,
  output logic                on_edge,
  output logic                done
);
  import dly_pkg::*;

  dly_st_t        st;
  logic [AW-1:0]  cap_cnt, n_idx;
  logic [LGW-1:0] lag, lo, hi, best_lag, lo_nx, hi_nx;
  logic [MW-1:0]  best_mag, mag_tab [LAGS];
  logic [MW-1:0]  cur_mag;
  logic           vld_d, trk_run, have_est, trk_go, edge_r;
  logic signed [FB:0] frac_new, div_frac;
  logic           div_fin;
  logic [2*W-1:0] ref_rd, fb_rd;
  logic [LGW-1:0] idx_l, idx_r;
  logic           pk_edge;

  dly_cap_ram #(.DW(2*W), .DEPTH(N)) u_ref_ram (
    .clk(clk), .we(st == S_CAP && smp_vld), .waddr(cap_cnt), .wdata({ref_i, ref_q}),
    .re(st == S_CORR), .raddr(n_idx), .rdata(ref_rd));

  dly_cap_ram #(.DW(2*W), .DEPTH(N)) u_fb_ram (
    .clk(clk), .we(st == S_CAP && smp_vld), .waddr(cap_cnt), .wdata({fb_i, fb_q}),
    .re(st == S_CORR), .raddr(n_idx + AW'(lag)), .rdata(fb_rd));

  dly_cmac #(.W(W), .ACCW(ACCW)) u_cmac (
    .clk(clk), .rst(rst), .clr(st == S_EVAL || st == S_CAP), .en(vld_d),
    .r_i(ref_rd[2*W-1:W]), .r_q(ref_rd[W-1:0]),
    .f_i(fb_rd[2*W-1:W]),  .f_q(fb_rd[W-1:0]),
    .mag(cur_mag));

  always_comb begin
    pk_edge = (best_lag == lo) || (best_lag == hi);
    idx_l   = pk_edge ? best_lag : best_lag - 1'b1;
    idx_r   = pk_edge ? best_lag : best_lag + 1'b1;
    trk_go  = track_en && have_est;
    lo_nx   = '0;
    hi_nx   = LGW'(LAGS - 1);
    if (trk_go) begin
      lo_nx = (int'(dly_int) >= TRK_SPAN) ? dly_int - LGW'(TRK_SPAN) : '0;
      hi_nx = (int'(dly_int) <= LAGS - 1 - TRK_SPAN) ? dly_int + LGW'(TRK_SPAN)
                                                      : LGW'(LAGS - 1);
    end
  end

  dly_frac_div #(.MW(MW), .FB(FB)) u_div (
    .clk(clk), .rst(rst), .go(st == S_FIT && !pk_edge),
    .m_l(mag_tab[idx_l]), .m_c(mag_tab[best_lag]), .m_r(mag_tab[idx_r]),
    .fin(div_fin), .frac(div_frac));

  always_ff @(posedge clk) begin
    if (st == S_EVAL) mag_tab[lag] <= cur_mag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      cap_cnt <= '0; n_idx <= '0; lag <= '0; lo <= '0; hi <= '0;
      best_lag <= '0; best_mag <= '0; vld_d <= 1'b0;
      trk_run <= 1'b0; have_est <= 1'b0; edge_r <= 1'b0; frac_new <= '0;
      dly_int <= '0; dly_frac <= '0; peak_mag <= '0; on_edge <= 1'b0; done <= 1'b0;
    end else begin
      vld_d <= (st == S_CORR);
      case (st)
        S_IDLE: if (start) begin
          done    <= 1'b0;
          trk_run <= trk_go;
          lo      <= lo_nx;
          hi      <= hi_nx;
          cap_cnt <= '0;
          st      <= S_CAP;
        end
        S_CAP: if (smp_vld) begin
          cap_cnt <= cap_cnt + 1'b1;
          if (cap_cnt == AW'(N - 1)) begin
            lag <= lo; n_idx <= '0; best_lag <= lo; best_mag <= '0;
            st  <= S_CORR;
          end
        end
        S_CORR: begin
          n_idx <= n_idx + 1'b1;
          if (n_idx == AW'(K - 1)) st <= S_WAIT;
        end
        S_WAIT: st <= S_EVAL;
        S_EVAL: begin
          if (lag == lo || cur_mag > best_mag) begin
            best_mag <= cur_mag;
            best_lag <= lag;
          end
          if (lag == hi) st <= S_FIT;
          else begin
            lag <= lag + 1'b1; n_idx <= '0; st <= S_CORR;
          end
        end
        S_FIT: begin
          edge_r   <= pk_edge;
          frac_new <= '0;
          st       <= pk_edge ? S_POST : S_DIV;
        end
        S_DIV: if (div_fin) begin
          frac_new <= div_frac;
          st       <= S_POST;
        end
        default: begin
          if (!trk_run || best_mag > trk_thr) begin
            dly_int  <= best_lag;
            dly_frac <= frac_new;
            peak_mag <= best_mag;
            on_edge  <= edge_r;
            have_est <= 1'b1;
          end
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dly_xcorr_est_chk.sv
module dly_xcorr_est_chk #(
  parameter int LGW = 6,
  parameter int FB  = 8,
  parameter int MW  = 26
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                done,
  input logic [LGW-1:0]      dly_int,
  input logic signed [FB:0]  dly_frac,
  input logic [MW-1:0]       peak_mag,
  input logic                on_edge
);
  localparam int FMAX = 1 << (FB - 1);

  // R7: an accepted start drops done on the next cycle
  a_r7_done_clears: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> !done);

  // R7: results move only together with the rising edge of done
  a_r7_hold_results: assert property (@(posedge clk) disable iff (rst)
    !(done && !$past(done)) |-> $stable({dly_int, dly_frac, peak_mag, on_edge}));

  // R5: fraction never leaves plus or minus one half sample
  a_r5_frac_range: assert property (@(posedge clk) disable iff (rst)
    (int'(dly_frac) <= FMAX) && (int'(dly_frac) >= -FMAX));

  // R6: an edge peak carries a zero fraction
  a_r6_edge_zero: assert property (@(posedge clk) disable iff (rst)
    on_edge |-> (dly_frac == '0));
endmodule

bind dly_xcorr_est dly_xcorr_est_chk #(.LGW(LGW), .FB(FB), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .dly_int(dly_int),
  .dly_frac(dly_frac), .peak_mag(peak_mag), .on_edge(on_edge));

// File: tb/dly_xcorr_est_test.sv
module dly_xcorr_est_test;
  localparam int W = 8, N = 64, LAGS = 16, FB = 8;
  localparam int K = N - LAGS;
  localparam int MW = 2*W + 1 + $clog2(N) + 1;
  localparam int LGW = $clog2(LAGS);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, track_en = 1'b0, smp_vld = 1'b0;
  logic [MW-1:0] trk_thr = '0;
  logic signed [W-1:0] ref_i = '0, ref_q = '0, fb_i = '0, fb_q = '0;
  logic [LGW-1:0] dly_int;
  logic signed [FB:0] dly_frac;
  logic [MW-1:0] peak_mag;
  logic on_edge, done;

  int n_chk = 0, n_bad = 0;
  int ri[N], rq[N], fi[N], fq[N];
  int m_int = 0, m_frac = 0, m_edge = 0, m_have = 0;
  longint m_peak = 0;

  always #2 clk = ~clk;

  dly_xcorr_est #(.W(W), .N(N), .LAGS(LAGS), .FB(FB)) uut (
    .clk(clk), .rst(rst), .start(start), .track_en(track_en), .trk_thr(trk_thr),
    .smp_vld(smp_vld), .ref_i(ref_i), .ref_q(ref_q), .fb_i(fb_i), .fb_q(fb_q),
    .dly_int(dly_int), .dly_frac(dly_frac), .peak_mag(peak_mag),
    .on_edge(on_edge), .done(done));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hx(input int k, input int s);
    logic [31:0] v;
    v = 32'(k + 5000) * 32'd2654435761 + 32'(s) * 32'd40503;
    v = v ^ (v >> 13);
    return int'($signed(v[20:14]));
  endfunction

  function automatic int mix(input int a, input int b, input int mode);
    if (mode == 1) return (a + b) >>> 1;
    if (mode == 2) return (3*a + b) >>> 2;
    return a;
  endfunction

  function automatic longint mag_at(input int L);
    longint re = 0, im = 0;
    for (int n = 0; n < K; n++) begin
      re += longint'(fi[n+L]) * ri[n] + longint'(fq[n+L]) * rq[n];
      im += longint'(fq[n+L]) * ri[n] - longint'(fi[n+L]) * rq[n];
    end
    return (re < 0 ? -re : re) + (im < 0 ? -im : im);
  endfunction

  // one run: build streams, predict per R2-R9, drive, compare
  task automatic run(input int d, input int mode, input int seed, input bit gaps,
                     input string tag);
    int lo, hi, pk, ef, fr;
    longint pm, ml, mr, dv;
    bit trk;
    for (int n = 0; n < N; n++) begin
      ri[n] = hx(n, seed);
      rq[n] = hx(n, seed + 77);
      fi[n] = mix(hx(n - d, seed), hx(n - d - 1, seed), mode);
      fq[n] = mix(hx(n - d, seed + 77), hx(n - d - 1, seed + 77), mode);
    end
    trk = track_en && (m_have != 0);
    lo = 0; hi = LAGS - 1;
    if (trk) begin  // R8 narrowed window
      lo = (m_int >= 2) ? m_int - 2 : 0;
      hi = (m_int <= LAGS - 3) ? m_int + 2 : LAGS - 1;
    end
    pk = lo; pm = mag_at(lo);
    for (int L = lo + 1; L <= hi; L++) if (mag_at(L) > pm) begin pm = mag_at(L); pk = L; end
    ef = (pk == lo || pk == hi) ? 1 : 0;
    fr = 0;
    if (ef == 0) begin
      ml = mag_at(pk - 1); mr = mag_at(pk + 1);
      dv = 2*pm - ml - mr;
      if (dv != 0) fr = int'(((mr - ml) * 128) / dv);
      if (fr > 128) fr = 128;
      if (fr < -128) fr = -128;
    end
    if (!trk || pm > longint'(trk_thr)) begin  // R9 acceptance
      m_int = pk; m_peak = pm; m_frac = fr; m_edge = ef; m_have = 1;
    end

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({tag, " R7 done low after start"}, done, 0);
    for (int k = 0; k < N; k++) begin
      if (gaps && (k % 3 == 1)) begin smp_vld = 1'b0; @(negedge clk); end
      smp_vld = 1'b1;
      ref_i = W'(ri[k]); ref_q = W'(rq[k]); fb_i = W'(fi[k]); fb_q = W'(fq[k]);
      @(negedge clk);
    end
    smp_vld = 1'b0;
    while (!done) @(negedge clk);
    chk({tag, " R3 dly_int"}, dly_int, m_int);
    chk({tag, " R3 peak_mag"}, peak_mag, m_peak);
    chk({tag, " R5 dly_frac"}, dly_frac, m_frac);
    chk({tag, " R6 on_edge"}, on_edge, m_edge);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 dly_int", dly_int, 0);
    chk("R1 dly_frac", dly_frac, 0);
    chk("R1 peak_mag", peak_mag, 0);
    chk("R1 on_edge", on_edge, 0);

    track_en = 1'b1;  // R4: no estimate yet, full search even with tracking on
    run(5, 0, 1, 1'b0, "R4 first run d5");
    track_en = 1'b0;
    run(9, 1, 2, 1'b1, "R2 gapped half-sample d9");
    run(7, 2, 3, 1'b0, "R5 quarter d7");
    run(0, 0, 4, 1'b0, "R6 low end d0");
    run(LAGS - 1, 0, 5, 1'b0, "R6 high end");
    run(8, 1, 6, 1'b0, "R4 calib d8");
    track_en = 1'b1; trk_thr = '0;
    run(8, 2, 7, 1'b0, "R8 track d8");
    run(12, 0, 8, 1'b0, "R8 drift past window");
    trk_thr = '1;
    run(3, 0, 9, 1'b0, "R9 rejected");
    trk_thr = '0;
    track_en = 1'b0;
    run(1, 1, 10, 1'b0, "R4 calib d1");
    track_en = 1'b1;
    run(1, 2, 11, 1'b0, "R8 clamp at zero");
    trk_thr = MW'(m_peak) - 1'b1;
    run(2, 1, 12, 1'b0, "R9 just above threshold");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule